// File: doc/BRIEF.md
# Programmable UART Baud Clock Generator

This block produces the one-cycle baud enable that paces a UART. A single 16-bit control register chooses the clock that feeds the chain. That clock is either the system clock or rising edges seen on an external clock pin. The chosen clock passes through an integer prescaler and then a power-of-two divider. The same register sets whether the external pin is driven or sampled.

When the pin is an output, the block drives it with a square wave that changes level on every baud tick. When the pin is an input and is chosen as the source, it is resynchronised into the system clock domain. Each rising edge then advances the prescaler by one count. Any register write restarts the division chain, so a new ratio begins from a clean count.

Top module: `baud_clkgen`

## Requirements
- R1: After reset the register reads 0x003F, and baud_tick, ext_clk_o and ext_clk_oe are all 0.
- R2: Register bits 15, 14, 12, 7 and 6 always read 0. Bits 13, 11, 10..8 and 5..0 read back the last value written.
- R3: The prescaler field is bits 5..0, holding a value f. With the system clock as source, the prescaler divides by 65 - f.
- R4: The divider field is bits 10..8, holding a value n. It divides the prescaler output by 2^n, so the tick period is (65 - f) * 2^n source counts.
- R5: baud_tick is high for exactly one system clock cycle. With the system clock as source, the first tick appears P cycles after the write edge and then repeats every P cycles, where P = (65 - f) * 2^n.
- R6: A register write clears the prescaler and divider counters and suppresses baud_tick in the following cycle, even when the write lands in the middle of a count.
- R7: When bit 11 is 1 and bit 13 is 0, every rising edge on ext_clk_i advances the prescaler by one count. The pin is synchronised through two flops before the edge is detected.
- R8: When bits 11 and 13 are both 1, the source is blocked and no baud_tick is produced.
- R9: ext_clk_oe equals bit 13. ext_clk_o toggles in the same cycle that baud_tick goes high.
- R10: A register write returns ext_clk_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value |
| ext_clk_i | input | 1 | External clock pin, input side |
| ext_clk_o | output | 1 | External clock pin, output side |
| ext_clk_oe | output | 1 | External clock pin output enable |
| baud_tick | output | 1 | One-cycle baud rate enable |

## Verification
Register readback is combinational, so it is compared in the cycle right after the write edge. With the system clock as source, the bench counts cycles from the write edge and expects baud_tick exactly at P and 2P and nowhere else. At the same samples it expects ext_clk_o to match the parity of the ticks seen so far. The external-source cases stop the pin and then wait several cycles, which covers the two synchroniser stages and the edge flop. Only then is the total tick count compared with the number of rising edges divided by P. All samples are taken on the falling edge, away from the edge that updates the design.

// File: rtl/baud_gen_pkg.sv
// Package: field positions, widths and reset value of the baud control register.
// Assumes a 16-bit register. Bit positions matter because software encodes them.
package baud_gen_pkg;
    localparam int REG_W       = 16;
    localparam int PRE_W       = 6;
    localparam int POW_W       = 3;
    localparam int PRE_LSB     = 0;
    localparam int POW_LSB     = 8;
    localparam int SRC_BIT     = 11;
    localparam int PIN_DIR_BIT = 13;
    localparam logic [REG_W-1:0] RST_VAL = 16'h003F;

    typedef struct packed {
        logic             pin_out;
        logic             src_ext;
        logic [POW_W-1:0] pow_sel;
        logic [PRE_W-1:0] pre_field;
    } bcg_cfg_t;
endpackage

// File: rtl/bcg_cfg_reg.sv
// Control register. It holds the live fields, builds the readback word with
// reserved bits forced to zero, and flags a write for one cycle.
// Assumes that wr_en is already qualified by the address decode.
module bcg_cfg_reg
    import baud_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output bcg_cfg_t         cfg,
    output logic [REG_W-1:0] rd_data
);
    // Capture the writable fields on a write, and load the reset value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.pin_out   <= RST_VAL[PIN_DIR_BIT];
            cfg.src_ext   <= RST_VAL[SRC_BIT];
            cfg.pow_sel   <= RST_VAL[POW_LSB +: POW_W];
            cfg.pre_field <= RST_VAL[PRE_LSB +: PRE_W];
        end else if (wr_en) begin
            cfg.pin_out   <= wr_data[PIN_DIR_BIT];
            cfg.src_ext   <= wr_data[SRC_BIT];
            cfg.pow_sel   <= wr_data[POW_LSB +: POW_W];
            cfg.pre_field <= wr_data[PRE_LSB +: PRE_W];
        end
    end

    // Build the readback word, with zeros in every reserved position.
    always_comb begin
        rd_data                     = '0;
        rd_data[PIN_DIR_BIT]        = cfg.pin_out;
        rd_data[SRC_BIT]            = cfg.src_ext;
        rd_data[POW_LSB +: POW_W]   = cfg.pow_sel;
        rd_data[PRE_LSB +: PRE_W]   = cfg.pre_field;
    end
endmodule

// File: rtl/bcg_pin_sync.sv
// Brings an asynchronous pin into the system clock domain through STAGES flops.
// It then gives a one-cycle pulse on each rising edge.
// Assumes that the pin stays at each level for at least two system clocks.
module bcg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_i};
    end

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/bcg_prescale.sv
// Integer prescaler. It counts source pulses and gives a one-cycle carry
// after (2^FIELD_W + 1 - field) of them. clr restarts the count.
// Assumes that field is stable between clears.
module bcg_prescale #(
    parameter int FIELD_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               pulse,
    input  logic [FIELD_W-1:0] field,
    output logic               carry
);
    localparam int MAX_RATIO = (1 << FIELD_W) + 1;
    localparam int CNT_W     = $clog2(MAX_RATIO);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;

    assign last_val = CNT_W'(MAX_RATIO) - CNT_W'(field) - CNT_W'(1);
    assign carry    = pulse && (cnt_q == last_val);

    // Advance on each source pulse, wrap at the ratio, and clear on a write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (carry)     cnt_q <= '0;
        else if (pulse)     cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/bcg_pow2_div.sv
// Power-of-two divider. It counts prescaler carries and gives a registered
// one-cycle tick every 2^sel carries. clr restarts the count and drops the tick.
// Assumes that sel is stable between clears.
module bcg_pow2_div #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] lim;
    logic             wrap;

    assign span = (CNT_W+1)'(1) << sel;
    assign lim  = CNT_W'(span - (CNT_W+1)'(1));
    assign wrap = step && (cnt_q == lim);

    // Count the carries from the prescaler, wrap at 2^sel, and clear on a write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (wrap)     cnt_q <= '0;
        else if (step)     cnt_q <= cnt_q + CNT_W'(1);
    end

    // Register the wrap as the baud tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) tick <= 1'b0;
        else               tick <= wrap;
    end
endmodule

// File: rtl/baud_clkgen.sv
// Top level of the baud clock generator. It picks the source, chains the
// prescaler and the power-of-two divider, and drives the external pin with a
// square wave at the tick rate. A register write restarts the chain.
// Assumes a single-register decode upstream and synchronous active-low reset.
module baud_clkgen
    import baud_gen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ext_clk_i,
    output logic             ext_clk_o,
    output logic             ext_clk_oe,
    output logic             baud_tick
);
    bcg_cfg_t cfg;
    logic     pin_rise;
    logic     src_pulse;
    logic     pre_carry;
    logic     pin_q;

    bcg_cfg_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    bcg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_clk_i),
        .rise_o (pin_rise)
    );

    // Pick the source: the system clock counts every cycle, the pin counts only
    // while it is an input.
    always_comb begin
        if (cfg.src_ext) src_pulse = pin_rise && !cfg.pin_out;
        else             src_pulse = 1'b1;
    end

    bcg_prescale #(.FIELD_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_en),
        .pulse (src_pulse),
        .field (cfg.pre_field),
        .carry (pre_carry)
    );

    bcg_pow2_div #(.SEL_W(POW_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_en),
        .step  (pre_carry),
        .sel   (cfg.pow_sel),
        .tick  (baud_tick)
    );

    // Toggle the pin level on each tick, and return it to 0 on a write.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_en)                    pin_q <= 1'b0;
        else if (pre_carry && u_div.wrap)       pin_q <= ~pin_q;
    end

    assign ext_clk_o  = pin_q;
    assign ext_clk_oe = cfg.pin_out;
endmodule

// File: rtl/bcg_chk.sv
// Checker for baud_clkgen, attached with bind. It only observes the ports.
module bcg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] rd_data,
    input logic        ext_clk_o,
    input logic        ext_clk_oe,
    input logic        baud_tick
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15:14] == 2'b00) && !rd_data[12] && (rd_data[7:6] == 2'b00));

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);

    // R6
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !baud_tick);

    // R8
    blocked_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[11] && rd_data[13] && !wr_en) |=> !baud_tick);

    // R9
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clk_oe == rd_data[13]);

    // R9
    pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(baud_tick) |-> (ext_clk_o != $past(ext_clk_o)));

    // R10
    wr_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ext_clk_o);
endmodule

bind baud_clkgen bcg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .ext_clk_o  (ext_clk_o),
    .ext_clk_oe (ext_clk_oe),
    .baud_tick  (baud_tick)
);

// File: tb/sim_baud_clkgen.sv
module sim_baud_clkgen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        ext_clk_i = 1'b0;
    logic        ext_clk_o;
    logic        ext_clk_oe;
    logic        baud_tick;

    int n_chk  = 0;
    int n_fail = 0;
    int tick_total = 0;

    baud_clkgen u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // running tick count, sampled away from the active edge
    always @(negedge clk) if (baud_tick) tick_total++;

    function automatic int period_of(int f, int n);
        return (65 - f) << n;
    endfunction

    function automatic logic [15:0] mask_rd(logic [15:0] d);
        return d & 16'h2F3F;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one write. The task returns on the negedge right after the write edge.
    task automatic write_reg(logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // With the system clock as source, check tick positions, tick width and pin parity.
    task automatic run_sys(int f, int n, logic pin_out);
        int p = period_of(f, n);
        int first = -1, second = -1, cnt = 0, width_err = 0, par_err = 0;
        logic prev = 1'b0;
        write_reg({2'b00, pin_out, 1'b0, 1'b0, 3'(n), 2'b00, 6'(f)});
        check("R10 pin low after write", int'(ext_clk_o), 0);
        check("R9 oe follows dir bit", int'(ext_clk_oe), int'(pin_out));
        for (int k = 0; k <= 2*p + 1; k++) begin
            if (k > 0) @(negedge clk);
            if (baud_tick) begin
                cnt++;
                if (first < 0) first = k;
                else if (second < 0) second = k;
                if (prev) width_err++;
            end
            if (int'(ext_clk_o) != (cnt % 2)) par_err++;
            prev = baud_tick;
        end
        check("R3 R4 R6 first tick cycle", first, p);
        check("R5 second tick cycle", second, 2*p);
        check("R5 tick count in window", cnt, 2);
        check("R5 tick one cycle wide", width_err, 0);
        check("R9 pin toggles per tick", par_err, 0);
    endtask

    // Drive rising edges on the pin, then let the synchroniser settle.
    task automatic pulse_pin(int edges);
        for (int e = 0; e < edges; e++) begin
            repeat (3) @(negedge clk);
            ext_clk_i = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk_i = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic run_all();
        int base;
        repeat (3) @(negedge clk);
        check("R1 reset readback", int'(rd_data), 16'h003F);
        check("R1 reset tick", int'(baud_tick), 0);
        check("R1 reset pin out", int'(ext_clk_o), 0);
        check("R1 reset oe", int'(ext_clk_oe), 0);
        rst_n = 1'b1;

        // R2: reserved bits read 0, writable fields read back
        write_reg(16'hFFFF);
        check("R2 all ones readback", int'(rd_data), int'(mask_rd(16'hFFFF)));
        write_reg(16'hC0C0);
        check("R2 reserved only readback", int'(rd_data), 0);
        for (int i = 0; i < 4; i++) begin
            logic [15:0] d = 16'($urandom);
            write_reg(d);
            check("R2 random readback", int'(rd_data), int'(mask_rd(d)));
        end

        // directed ratio corners (R3, R4, R5)
        run_sys(63, 0, 1'b0);
        run_sys(0, 0, 1'b0);
        run_sys(63, 7, 1'b1);
        run_sys(0, 7, 1'b0);
        run_sys(32, 3, 1'b1);
        // random ratios; each starts mid-count from the previous run (R6)
        for (int i = 0; i < 8; i++) begin
            run_sys(int'($urandom % 64), int'($urandom % 6), 1'($urandom % 2));
        end

        // R7: pin as source, ratio 3, divider 2, so P = 6 edges
        write_reg(16'h0100 | 16'h0800 | 16'd62);
        base = tick_total;
        pulse_pin(12);
        check("R7 ticks from pin edges", tick_total - base, 2);
        base = tick_total;
        pulse_pin(5);
        check("R7 partial count no tick", tick_total - base, 0);
        base = tick_total;
        pulse_pin(1);
        check("R7 sixth edge ticks", tick_total - base, 1);

        // R8: pin source while pin is an output -> blocked
        write_reg(16'h2000 | 16'h0800 | 16'd63);
        base = tick_total;
        pulse_pin(10);
        check("R8 blocked source no tick", tick_total - base, 0);
        check("R8 oe high", int'(ext_clk_oe), 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        fork
            run_all();
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule